// File: doc/BRIEF.md
# Serial EEPROM Target Engine

This block is the protocol side of a small two-wire (I2C) memory target. It watches oversampled SCL and SDA lines, finds start and stop conditions, and checks the 7-bit device address. It then runs the byte-level exchange that makes a 128-byte array behave like a serial EEPROM. It acknowledges by pulling SDA low through an open-drain enable. It keeps a word-address counter that survives between transactions.

Writes are not stored here. Each received data byte is handed to an outside page-buffer/commit block as a strobe with an address and a data byte. A stop that ends a write sends a single commit pulse to that block. While the block reports `busy` (its self-timed write), the engine stays silent. It does not even acknowledge its own device address, so a host can poll until the write has finished. Read data comes from the array through a combinational read port that the word-address counter addresses.

Supported transfers are byte and page writes, current-address reads, random reads (a write header followed by a repeated start) and sequential reads. Write addressing wraps inside an 8-byte page. Read addressing wraps across the whole array.

Top module: `serial_mem_target`

## Requirements
- R1: After reset, `sda_oe` is low, no write strobe or commit pulse is issued, and the word-address counter is 0, so a first current-address read returns the byte at address 0.
- R2: A start is an SDA fall while synchronized SCL is high, and a stop is an SDA rise while SCL is high. A start at any point, including in the middle of a transfer, restarts reception of the device-address byte.
- R3: The device-address byte is received MSB first, with the address in bits 7..1 and R/W in bit 0 (1 = read). The engine pulls SDA low in the ninth clock only when the address equals the `DEV_ADDR` parameter (0x50 by default). On a mismatch it leaves SDA released and ignores everything until the next start.
- R4: In a write, the byte after the device address loads the word-address counter from its bits 6..0. Bit 7 is ignored. The word-address byte and every data byte are acknowledged with a low SDA.
- R5: Each received data byte produces exactly one `wr_en` pulse that carries the byte (received MSB first) on `wr_data` and the counter value on `wr_addr`.
- R6: After each written byte, the low 3 counter bits advance modulo 8 and the upper 4 bits are kept. A ninth byte in one page write therefore lands on the first written address again.
- R7: A stop that follows at least one data byte gives one `wr_commit` pulse. A transaction with no data bytes (such as the dummy write of a random read) gives none.
- R8: In a read, the engine drives the byte at the counter MSB first. After each byte the counter advances by one modulo 128, so 0x7F is followed by 0x00.
- R9: A host acknowledge (SDA low in the ninth clock) makes the engine send the next byte. A host no-acknowledge makes it release SDA and stay silent until a start or stop.
- R10: The counter keeps its value between transactions. A current-address read returns the byte after the last one written or read, following the wrap rules of R6 and R8.
- R11: While `busy` is high, SDA is never pulled low, not even for a matching device address. Once `busy` falls, a new header is acknowledged again.
- R12: `sda_oe` changes only while synchronized SCL is low, except when it is released because of a start, a stop or `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line |
| sda_in | input | 1 | Raw serial data line |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| busy | input | 1 | Commit block is in its self-timed write |
| rd_addr | output | 7 | Read port address (the word-address counter) |
| rd_data | input | 8 | Array byte at `rd_addr` |
| wr_en | output | 1 | One-cycle strobe per received data byte |
| wr_addr | output | 7 | Target address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_commit | output | 1 | One-cycle pulse: start the self-timed write |

## Verification
On the clock edge that issues a write strobe, the counter also takes its page-wrapped step. The strobe must still carry the old address while `rd_addr` already shows the wrapped one. This is provoked by page writes that start near the end of a page and cross the boundary, one of them ten bytes long so that it overwrites itself. The page is then read back sequentially and compared with a model that applies modulo-8 wrapping. A second collision is a header that arrives right after the commit pulse, while `busy` is rising. The test is judged by a released acknowledge bit, followed by polling with a read header until the acknowledge returns and the page-wrapped next byte is delivered.

// File: rtl/smt_pkg.sv
`timescale 1ns/1ps
// smt_pkg: shared types for the serial EEPROM target engine.
// Assumes: nothing beyond IEEE 1800-2017.
package smt_pkg;

    // Protocol engine phases
    typedef enum logic [2:0] {
        EP_IDLE  = 3'd0,   // released, waiting for a start
        EP_DEV   = 3'd1,   // receiving the device-address byte
        EP_WORD  = 3'd2,   // receiving the word-address byte
        EP_WDATA = 3'd3,   // receiving write data bytes
        EP_RDATA = 3'd4    // transmitting read data bytes
    } eng_state_t;

endpackage

// File: rtl/smt_sync.sv
`timescale 1ns/1ps
// smt_sync: brings SCL and SDA into the clock domain through a flop chain
// and derives SCL edges plus start/stop conditions from the synchronized
// levels.
// Assumes: both lines stay stable for several clocks between changes.
module smt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev_q;

    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;

        // Shift the raw line through the synchronizer chain (idle level high)
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw[g]};
            end
        end

        assign synced[g] = chain_q[STAGES-1];
    end

    // Keep the previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '1;
        end else begin
            prev_q <= synced;
        end
    end

    assign scl_s     = synced[1];
    assign sda_s     = synced[0];
    assign scl_rise  =  synced[1] & ~prev_q[1];
    assign scl_fall  = ~synced[1] &  prev_q[1];
    assign start_det =  synced[1] &  prev_q[1] &  prev_q[0] & ~synced[0];
    assign stop_det  =  synced[1] &  prev_q[1] & ~prev_q[0] &  synced[0];

endmodule

// File: rtl/smt_addr.sv
`timescale 1ns/1ps
// smt_addr: word-address counter. Load wins over stepping. A page step
// wraps inside a 2**PAGE_BITS page and a full step wraps across the array.
// Assumes: at most one of the step requests is active in a cycle.
module smt_addr #(
    parameter int ADDR_W    = 7,
    parameter int PAGE_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              step_page,
    input  logic              step_full,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] page_next;

    if (PAGE_BITS > 0 && PAGE_BITS < ADDR_W) begin : g_split
        assign page_next = {addr_q[ADDR_W-1:PAGE_BITS],
                            addr_q[PAGE_BITS-1:0] + PAGE_BITS'(1)};
    end else begin : g_flat
        assign page_next = addr_q + ADDR_W'(1);
    end

    // Update the counter on a load, a page step or a full step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (ld_en) begin
            addr_q <= ld_val;
        end else if (step_page) begin
            addr_q <= page_next;
        end else if (step_full) begin
            addr_q <= addr_q + ADDR_W'(1);
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/smt_engine.sv
`timescale 1ns/1ps
// smt_engine: byte-level protocol of the serial EEPROM target. It receives
// header, word-address and data bytes, acknowledges them, transmits read
// data, issues write strobes and the commit pulse, and stays silent while
// the commit block is busy.
// Assumes: the edge and condition flags come from one synchronizer, and
// rd_data is valid in the same cycle as the counter address.
module smt_engine
    import smt_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter int          DATA_W   = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_commit,
    output logic              ld_en,
    output logic [ADDR_W-1:0] ld_val,
    output logic              step_page,
    output logic              step_full
);

    localparam int              CNT_W  = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] B_LAST = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] B_ACKD = CNT_W'(DATA_W + 1);
    localparam int              MSB    = DATA_W - 1;

    eng_state_t        state_q;
    logic [CNT_W-1:0]  bit_q;
    logic              ackph_q;
    logic              rw_q;
    logic              pend_q;
    logic              oe_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] tx_q;
    logic              wr_en_q;
    logic              commit_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;

    logic live;
    logic rx_phase;
    logic rx_shift;
    logic rx_done;
    logic ack_end;
    logic dev_hit;
    logic tx_rise;
    logic tx_fall;

    // Decode the events that move the engine in this cycle
    always_comb begin
        live     = !stop_det && !start_det && !busy;
        rx_phase = (state_q == EP_DEV) || (state_q == EP_WORD) ||
                   (state_q == EP_WDATA);
        rx_shift = live && scl_rise && rx_phase && (bit_q < B_LAST);
        rx_done  = live && scl_fall && rx_phase && (bit_q == B_LAST) && !ackph_q;
        ack_end  = live && scl_fall && rx_phase && ackph_q;
        dev_hit  = (rx_q[DATA_W-1:1] == DEV_ADDR);
        tx_rise  = live && scl_rise && (state_q == EP_RDATA);
        tx_fall  = live && scl_fall && (state_q == EP_RDATA);
    end

    // Requests to the word-address counter
    always_comb begin
        ld_en     = rx_done && (state_q == EP_WORD);
        ld_val    = rx_q[ADDR_W-1:0];
        step_page = rx_done && (state_q == EP_WDATA);
        step_full = tx_fall && (bit_q == B_LAST);
    end

    // Protocol state, shift registers, line drive and write strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= EP_IDLE;
            bit_q     <= '0;
            ackph_q   <= 1'b0;
            rw_q      <= 1'b0;
            pend_q    <= 1'b0;
            oe_q      <= 1'b0;
            rx_q      <= '0;
            tx_q      <= '0;
            wr_en_q   <= 1'b0;
            commit_q  <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q  <= 1'b0;
            commit_q <= 1'b0;
            if (stop_det) begin
                state_q  <= EP_IDLE;
                oe_q     <= 1'b0;
                ackph_q  <= 1'b0;
                commit_q <= pend_q;
                pend_q   <= 1'b0;
            end else if (busy) begin
                state_q <= EP_IDLE;
                oe_q    <= 1'b0;
                ackph_q <= 1'b0;
            end else if (start_det) begin
                state_q <= EP_DEV;
                bit_q   <= '0;
                ackph_q <= 1'b0;
                oe_q    <= 1'b0;
            end else begin
                if (rx_shift) begin
                    rx_q  <= {rx_q[DATA_W-2:0], sda_s};
                    bit_q <= bit_q + CNT_W'(1);
                end
                if (rx_done) begin
                    case (state_q)
                        EP_DEV: begin
                            if (dev_hit && !busy) begin
                                oe_q    <= 1'b1;
                                ackph_q <= 1'b1;
                                rw_q    <= rx_q[0];
                            end else begin
                                state_q <= EP_IDLE;
                            end
                        end
                        EP_WORD: begin
                            oe_q    <= 1'b1;
                            ackph_q <= 1'b1;
                        end
                        EP_WDATA: begin
                            oe_q      <= 1'b1;
                            ackph_q   <= 1'b1;
                            wr_en_q   <= 1'b1;
                            wr_addr_q <= cur_addr;
                            wr_data_q <= rx_q;
                            pend_q    <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (ack_end) begin
                    oe_q    <= 1'b0;
                    ackph_q <= 1'b0;
                    bit_q   <= '0;
                    case (state_q)
                        EP_DEV: begin
                            if (rw_q) begin
                                state_q <= EP_RDATA;
                                tx_q    <= rd_data;
                                oe_q    <= ~rd_data[MSB];
                            end else begin
                                state_q <= EP_WORD;
                            end
                        end
                        EP_WORD: state_q <= EP_WDATA;
                        default: ;
                    endcase
                end
                if (tx_rise) begin
                    if (bit_q < B_LAST) begin
                        bit_q <= bit_q + CNT_W'(1);
                    end else if (bit_q == B_LAST) begin
                        if (!sda_s) begin
                            bit_q <= B_ACKD;
                        end else begin
                            state_q <= EP_IDLE;
                        end
                    end
                end
                if (tx_fall) begin
                    if (bit_q != '0 && bit_q < B_LAST) begin
                        tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                        oe_q <= ~tx_q[MSB-1];
                    end else if (bit_q == B_LAST) begin
                        oe_q <= 1'b0;
                    end else if (bit_q == B_ACKD) begin
                        tx_q  <= rd_data;
                        oe_q  <= ~rd_data[MSB];
                        bit_q <= '0;
                    end
                end
            end
        end
    end

    assign sda_oe    = oe_q;
    assign wr_en     = wr_en_q;
    assign wr_addr   = wr_addr_q;
    assign wr_data   = wr_data_q;
    assign wr_commit = commit_q;

    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        commit_q |-> $past(stop_det)); // R7

    AST_SILENT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !oe_q); // R11

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> (!$past(scl_s) || $past(start_det || stop_det || busy))); // R12

    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en_q, commit_q})); // R5

endmodule

// File: rtl/serial_mem_target.sv
`timescale 1ns/1ps
// serial_mem_target: two-wire serial EEPROM target. It connects the line
// synchronizer, the protocol engine and the word-address counter.
// Assumes: an outside commit block takes wr_en/wr_commit and raises busy
// during its self-timed write; rd_data follows rd_addr combinationally.
module serial_mem_target #(
    parameter int         ADDR_W      = 7,
    parameter int         DATA_W      = 8,
    parameter int         PAGE_BITS   = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              busy,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_commit
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              ld_en, step_page, step_full;
    logic [ADDR_W-1:0] ld_val;
    logic [ADDR_W-1:0] cur_addr;

    smt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smt_engine #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .busy      (busy),
        .rd_data   (rd_data),
        .cur_addr  (cur_addr),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit),
        .ld_en     (ld_en),
        .ld_val    (ld_val),
        .step_page (step_page),
        .step_full (step_full)
    );

    smt_addr #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (ld_en),
        .ld_val    (ld_val),
        .step_page (step_page),
        .step_full (step_full),
        .addr      (cur_addr)
    );

    assign rd_addr = cur_addr;

    if (PAGE_BITS > 0 && PAGE_BITS < ADDR_W) begin : g_page_chk
        AST_PAGE_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> (rd_addr == {wr_addr[ADDR_W-1:PAGE_BITS],
                                   wr_addr[PAGE_BITS-1:0] + PAGE_BITS'(1)})); // R6
    end

endmodule

// File: tb/serial_mem_target_test.sv
`timescale 1ns/100ps
module serial_mem_target_test;

    localparam int Q    = 8;      // clocks per quarter bit
    localparam int BUSY = 400;    // self-timed write length in clocks
    localparam int WDOG = 150000;
    localparam logic [23:0] VEC [0:3] = '{24'h10_01_A5, 24'h2E_0A_30,
                                          24'h7D_03_55, 24'h40_08_11};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_scl = 1'b1;
    logic       host_sda = 1'b1;
    logic       sda_oe, busy, wr_en, wr_commit;
    logic [6:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic       sda_line;

    logic [7:0] mem   [128];
    logic [7:0] model [128];
    logic [6:0] pa    [64];
    logic [7:0] pd    [64];
    int pn = 0, busy_cnt = 0, strobe_cnt = 0, commit_cnt = 0, oe_viol = 0;
    logic [6:0] last_wa = '0;
    logic       prev_oe = 1'b0;
    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = host_sda & ~sda_oe;
    assign rd_data  = mem[rd_addr];
    assign busy     = (busy_cnt != 0);

    serial_mem_target uut (
        .clk(clk), .rst_n(rst_n), .scl_in(host_scl), .sda_in(sda_line),
        .sda_oe(sda_oe), .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
    );

    // Commit block model, strobe counters and line-discipline monitor
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] = 8'(i * 7 + 3);
            pn = 0; busy_cnt = 0;
        end else begin
            if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
            if (wr_en) begin
                strobe_cnt++; last_wa = wr_addr;
                pa[pn] = wr_addr; pd[pn] = wr_data; pn++;
            end
            if (wr_commit) begin
                commit_cnt++;
                for (int i = 0; i < pn; i++) mem[pa[i]] = pd[i];
                pn = 0; busy_cnt = BUSY;
            end
            if (sda_oe !== prev_oe && host_scl) oe_viol++;
            prev_oe = sda_oe;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic h_start();
        host_sda = 1'b1; tick(Q); host_scl = 1'b1; tick(Q);
        host_sda = 1'b0; tick(Q); host_scl = 1'b0; tick(Q);
    endtask

    task automatic h_stop();
        host_sda = 1'b0; tick(Q); host_scl = 1'b1; tick(Q);
        host_sda = 1'b1; tick(Q);
    endtask

    task automatic h_bit_out(input logic b);
        host_sda = b; tick(Q); host_scl = 1'b1; tick(2 * Q);
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic h_bit_in(output logic b);
        host_sda = 1'b1; tick(Q); host_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q); host_scl = 1'b0; tick(Q);
    endtask

    task automatic h_send(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) h_bit_out(v[i]);
        h_bit_in(ack);
    endtask

    task automatic h_recv(input logic host_ack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin h_bit_in(b); v[i] = b; end
        h_bit_out(host_ack);
    endtask

    // Repeat start + header until the target acknowledges
    task automatic poll(input logic rw, output int tries);
        logic ack;
        tries = 0;
        do begin
            h_start(); h_send({7'h50, rw}, ack); tries++;
            if (ack) h_stop();
        end while (ack && tries < 40);
    endtask

    initial begin
        logic ack, nack_seen;
        logic [7:0] v;
        int tries, sc, cc;
        logic [6:0] s, pg;
        int n;
        logic [7:0] d;

        for (int i = 0; i < 128; i++) model[i] = 8'(i * 7 + 3);
        tick(10);
        rst_n = 1'b1;
        tick(4);

        // Reset state (R1)
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
        chk("R1 no strobes after reset", strobe_cnt + commit_cnt, 0);

        // Current-address read right after reset (R1, R3, R10)
        h_start(); h_send(8'hA1, ack);
        chk("R3 own read header acked", int'(ack), 0);
        h_recv(1'b1, v); h_stop();
        chk("R1 counter starts at 0", int'(v), int'(model[0]));
        h_start(); h_send(8'hA1, ack); h_recv(1'b1, v); h_stop();
        chk("R10 counter kept between reads", int'(v), int'(model[1]));

        // Foreign device address (R3)
        sc = strobe_cnt;
        h_start(); h_send(8'hA2, ack);
        chk("R3 mismatch not acked", int'(ack), 1);
        h_send(8'h00, ack);
        chk("R3 silent after mismatch", int'(ack), 1);
        h_send(8'h12, ack); h_stop();
        chk("R3 no strobe after mismatch", strobe_cnt, sc);

        // Vector table: page write then sequential page readback
        for (int e = 0; e < 4; e++) begin
            s = VEC[e][23:17]; n = int'(VEC[e][15:8]); d = VEC[e][7:0];
            pg = {s[6:3], 3'b000};
            sc = strobe_cnt; cc = commit_cnt; nack_seen = 1'b0;
            poll(1'b0, tries);
            h_send({1'b0, s}, ack); nack_seen |= ack;
            for (int i = 0; i < n; i++) begin
                h_send(d + 8'(i), ack); nack_seen |= ack;
                model[{s[6:3], s[2:0] + 3'(i)}] = d + 8'(i);
            end
            h_stop();
            chk("R4 word and data bytes acked", int'(nack_seen), 0);
            chk("R5 one strobe per data byte", strobe_cnt - sc, n);
            chk("R6 last strobe address wraps in page", int'(last_wa),
                int'({s[6:3], s[2:0] + 3'(n - 1)}));
            tick(2);
            chk("R7 one commit per write", commit_cnt - cc, 1);
            poll(1'b0, tries);
            h_send({1'b0, pg}, ack);
            h_start(); h_send(8'hA1, ack);
            for (int i = 0; i < 8; i++) begin
                h_recv(i == 7, v);
                chk("R6 R8 page readback", int'(v), int'(model[pg + 7'(i)]));
            end
            h_stop();
            chk("R7 dummy write gives no commit", commit_cnt - cc, 1);
        end

        // Busy silence and acknowledge polling, page-wrapped counter (R11, R6, R10)
        poll(1'b0, tries);
        h_send(8'h56, ack); h_send(8'hC1, ack); h_send(8'hC2, ack); h_stop();
        model[7'h56] = 8'hC1; model[7'h57] = 8'hC2;
        h_start(); h_send(8'hA0, ack); h_stop();
        chk("R11 own address not acked while busy", int'(ack), 1);
        poll(1'b1, tries);
        chk("R11 acked again after busy", int'(tries < 40), 1);
        h_recv(1'b1, v); h_stop();
        chk("R6 R10 counter wrapped to page start", int'(v), int'(model[7'h50]));

        // Read wrap and ignored word-address MSB (R2, R4, R8, R9, R10)
        cc = commit_cnt;
        poll(1'b0, tries);
        h_send(8'hFE, ack);
        h_start(); h_send(8'hA1, ack);
        chk("R2 repeated start header acked", int'(ack), 0);
        h_recv(1'b0, v);
        chk("R4 word MSB ignored", int'(v), int'(model[7'h7E]));
        h_recv(1'b0, v);
        chk("R8 byte at 7F", int'(v), int'(model[7'h7F]));
        h_recv(1'b1, v);
        chk("R8 wrap to 00", int'(v), int'(model[7'h00]));
        h_recv(1'b1, v);
        chk("R9 silent after host nack", int'(v), 8'hFF);
        h_stop();
        h_start(); h_send(8'hA1, ack); h_recv(1'b1, v); h_stop();
        chk("R10 next after wrap", int'(v), int'(model[7'h01]));
        chk("R7 no commit without data", commit_cnt - cc, 0);

        chk("R12 sda_oe steady while SCL high", oe_viol, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule